// File: doc/BRIEF.md
# RTC Alarm and Second-Adjust Unit

This block is the counting core of a real-time clock. A fast base tick is divided down to a one-second step that drives second, minute, hour and weekday counters. The counters are compared against alarm values for minute, hour and weekday. Each field has its own enable, so an alarm can fire once per hour, once per day or once per week.

Software reaches the block through one 8-bit flag and control register on a simple strobe bus. The register holds an alarm flag, a once-per-minute flag, the alarm interrupt enable and two write-only adjustment commands. One command rounds the time to the nearest minute. The other restarts the current second from zero. A read-only bit shows while an adjustment is being applied.

Both flags are cleared by a read-then-write handshake, so a flag that is raised after software sampled it is not lost. The alarm flag can also be dropped by a clear pulse from an automatic transfer controller. A single interrupt line combines the enabled alarm flag with the periodic flag.

Top module: `rtc_alarm_adj`

## Requirements
- R1: Register bits: 0 is the alarm flag, 1 is the minute flag, 2 is the alarm enable, 3 is the round command, 4 is the second-restart command, and 7 is the adjust-busy bit. Bits 5 and 6 always read 0. After `rst_n` every bit reads 0.
- R2: Writing 0 to a flag bit clears it only if the most recent read returned that flag as 1. Any write ends that permission. A flag that was read as 0 and then set keeps its value when 0 is written.
- R3: Writing 1 to bit 0 or bit 1 never changes either flag.
- R4: A pulse on `xfer_clr` clears the alarm flag. A new alarm in the same cycle wins.
- R5: The alarm flag sets in the cycle in which the minute count advances, when every enabled field (`alm_en` bit 0 minute, bit 1 hour, bit 2 weekday) equals its alarm value and at least one field is enabled. A match that persists across later second steps does not set the flag again.
- R6: The minute flag sets on every minute advance, whether from a natural rollover or from a round command.
- R7: `irq` is 1 exactly when (alarm flag AND alarm enable) OR minute flag.
- R8: A round command sets seconds to 0. If seconds were 30 or more, it also advances the minute, carrying into hour and weekday.
- R9: A second-restart command sets seconds to 0 and restarts the sub-second divider, so a full `TICKS_PER_SEC` base ticks are needed for the next second.
- R10: Command bits 3 and 4 read 0. Bit 7 reads 1 for exactly the one cycle after a command write, during which the adjustment is applied.
- R11: `TICKS_PER_SEC` base ticks make one second. Seconds and minutes wrap 59 to 0, hours wrap 23 to 0, and weekday wraps 6 to 0, each carrying into the next field.
- R12: In the cycle an adjustment is applied, it takes precedence over a coinciding second step, and that step is dropped.
- R13: A pulse on `clk_rst` zeroes all register bits, all time counters and the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_rst | input | 1 | Synchronous clock-reset command |
| base_tick | input | 1 | Sub-second base tick |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| xfer_clr | input | 1 | Alarm-flag clear pulse from transfer controller |
| alm_min | input | 6 | Alarm minute value |
| alm_hour | input | 5 | Alarm hour value |
| alm_wday | input | 3 | Alarm weekday value |
| alm_en | input | 3 | Alarm field enables (minute, hour, weekday) |
| sec_o | output | 6 | Current seconds |
| min_o | output | 6 | Current minutes |
| hour_o | output | 5 | Current hours |
| wday_o | output | 3 | Current weekday |
| irq | output | 1 | Interrupt request |

## Verification
An adjustment and a second step from the divider can fall on the same cycle. The bench provokes this by placing the divider one base tick short of a second and writing a round command while seconds are past 30. It then drives a base tick exactly in the apply cycle. The bench expects seconds to read 0 rather than 1 and the minute to have advanced by one. This shows that the adjustment took precedence and that the second step was dropped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
  } rtc_time_t;

  localparam int unsigned REG_W      = 8;
  localparam int unsigned B_ALM_FLAG = 0;
  localparam int unsigned B_MIN_FLAG = 1;
  localparam int unsigned B_ALM_IE   = 2;
  localparam int unsigned B_ROUND    = 3;
  localparam int unsigned B_SECRST   = 4;
  localparam int unsigned B_BUSY     = 7;

  localparam int unsigned SEC_TOP  = 59;
  localparam int unsigned MIN_TOP  = 59;
  localparam int unsigned HOUR_TOP = 23;
  localparam int unsigned WDAY_TOP = 6;
  localparam int unsigned ROUND_AT = 30;

  // Modular step: value after one increment in range 0..top
  function automatic int unsigned step_mod(input int unsigned v, input int unsigned top);
    return (v >= top) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic base_tick,
  output logic sec_step
);
  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  assign sec_step = base_tick && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (base_tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      sec_step,
  input  logic      adj_go,
  input  logic      round_go,
  output rtc_time_t now_q,
  output rtc_time_t now_nx,
  output logic      min_step
);
  logic sec_wrap, min_wrap, hour_wrap;

  always_comb begin
    now_nx    = now_q;
    min_step  = 1'b0;
    sec_wrap  = (32'(now_q.sec)  == SEC_TOP);
    min_wrap  = (32'(now_q.min)  == MIN_TOP);
    hour_wrap = (32'(now_q.hour) == HOUR_TOP);
    if (adj_go) begin
      // adjustment overrides any coinciding second step
      now_nx.sec = '0;
      min_step   = round_go && (32'(now_q.sec) >= ROUND_AT);
    end else if (sec_step) begin
      now_nx.sec = 6'(step_mod(32'(now_q.sec), SEC_TOP));
      min_step   = sec_wrap;
    end
    if (min_step) begin
      now_nx.min = 6'(step_mod(32'(now_q.min), MIN_TOP));
      if (min_wrap) begin
        now_nx.hour = 5'(step_mod(32'(now_q.hour), HOUR_TOP));
        if (hour_wrap) now_nx.wday = 3'(step_mod(32'(now_q.wday), WDAY_TOP));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   now_q <= '0;
    else if (clr) now_q <= '0;
    else          now_q <= now_nx;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  rtc_time_t  now_nx,
  input  logic       min_step,
  input  logic [5:0] alm_min,
  input  logic [4:0] alm_hour,
  input  logic [2:0] alm_wday,
  input  logic [2:0] alm_en,
  output logic       alarm_hit
);
  logic [2:0] fld_eq;
  logic [2:0] fld_ok;

  assign fld_eq = {now_nx.wday == alm_wday, now_nx.hour == alm_hour, now_nx.min == alm_min};

  for (genvar g = 0; g < 3; g++) begin : g_fld
    assign fld_ok[g] = !alm_en[g] || fld_eq[g];
  end

  // evaluated only on the cycle the minute count changes
  assign alarm_hit = min_step && (|alm_en) && (&fld_ok);
endmodule

// File: rtl/rtc_alarm_adj.sv
module rtc_alarm_adj
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_rst,
  input  logic       base_tick,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       xfer_clr,
  input  logic [5:0] alm_min,
  input  logic [4:0] alm_hour,
  input  logic [2:0] alm_wday,
  input  logic [2:0] alm_en,
  output logic [5:0] sec_o,
  output logic [5:0] min_o,
  output logic [4:0] hour_o,
  output logic [2:0] wday_o,
  output logic       irq
);
  logic      alm_flag, min_flag, alm_ie;
  logic      seen_alm, seen_min;
  logic      round_pend, secrst_pend;
  logic      sec_step, min_step, alarm_hit;
  logic      adj_go, alm_wclr, min_wclr;
  logic      unused_wbits;
  rtc_time_t now_q, now_nx;

  assign adj_go       = round_pend || secrst_pend;
  assign alm_wclr     = wr_stb && !wdata[B_ALM_FLAG] && seen_alm;
  assign min_wclr     = wr_stb && !wdata[B_MIN_FLAG] && seen_min;
  assign unused_wbits = ^wdata[7:5];

  rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clk_rst || secrst_pend),
    .base_tick (base_tick),
    .sec_step  (sec_step)
  );

  rtc_time u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clk_rst),
    .sec_step (sec_step),
    .adj_go   (adj_go),
    .round_go (round_pend),
    .now_q    (now_q),
    .now_nx   (now_nx),
    .min_step (min_step)
  );

  rtc_alarm_cmp u_cmp (
    .now_nx    (now_nx),
    .min_step  (min_step),
    .alm_min   (alm_min),
    .alm_hour  (alm_hour),
    .alm_wday  (alm_wday),
    .alm_en    (alm_en),
    .alarm_hit (alarm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flag <= 1'b0; min_flag <= 1'b0; alm_ie <= 1'b0;
      seen_alm <= 1'b0; seen_min <= 1'b0;
      round_pend <= 1'b0; secrst_pend <= 1'b0;
    end else if (clk_rst) begin
      alm_flag <= 1'b0; min_flag <= 1'b0; alm_ie <= 1'b0;
      seen_alm <= 1'b0; seen_min <= 1'b0;
      round_pend <= 1'b0; secrst_pend <= 1'b0;
    end else begin
      round_pend  <= wr_stb && wdata[B_ROUND];
      secrst_pend <= wr_stb && wdata[B_SECRST];
      if (wr_stb) alm_ie <= wdata[B_ALM_IE];
      // set events take precedence over every clear source
      if (alarm_hit)                 alm_flag <= 1'b1;
      else if (xfer_clr || alm_wclr) alm_flag <= 1'b0;
      if (min_step)      min_flag <= 1'b1;
      else if (min_wclr) min_flag <= 1'b0;
      // clear permission: captured at a read, consumed by any write
      if (wr_stb) begin
        seen_alm <= 1'b0;
        seen_min <= 1'b0;
      end else if (rd_stb) begin
        seen_alm <= alm_flag;
        seen_min <= min_flag;
      end
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[B_ALM_FLAG] = alm_flag;
    rdata[B_MIN_FLAG] = min_flag;
    rdata[B_ALM_IE]   = alm_ie;
    rdata[B_BUSY]     = adj_go;
  end

  assign irq    = (alm_flag && alm_ie) || min_flag;
  assign sec_o  = now_q.sec;
  assign min_o  = now_q.min;
  assign hour_o = now_q.hour;
  assign wday_o = now_q.wday;
endmodule

// File: rtl/rtc_alarm_adj_chk.sv
module rtc_alarm_adj_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_rst,
  input logic       wr_stb,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       xfer_clr,
  input logic       irq,
  input logic [5:0] sec_o,
  input logic [5:0] min_o,
  input logic [4:0] hour_o,
  input logic [2:0] wday_o,
  input logic       alarm_hit,
  input logic       min_step
);
  // R1 and R10: reserved and command bits never read as 1
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:3] == 4'b0000);

  assert_alarm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit && !clk_rst |=> rdata[0]);

  assert_min_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    min_step && !clk_rst |=> rdata[1]);

  assert_alm_clear_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[0]) |-> $past(xfer_clr || wr_stb || clk_rst));

  assert_xfer_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_clr && !alarm_hit |=> !rdata[0]);

  assert_irq_from_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[1] |-> irq);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[1] && !(rdata[0] && rdata[2]) |-> !irq);

  assert_busy_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7] && !(wr_stb && (wdata[4:3] != 2'b00)) |=> !rdata[7]);

  assert_adj_zero_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7] && !clk_rst |=> sec_o == 6'd0);

  assert_ranges_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o < 6'd60 && min_o < 6'd60 && hour_o < 5'd24 && wday_o < 3'd7);

  assert_clk_rst_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rst |=> rdata == 8'h00 && sec_o == 6'd0 && min_o == 6'd0);
endmodule

bind rtc_alarm_adj rtc_alarm_adj_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_rst   (clk_rst),
  .wr_stb    (wr_stb),
  .wdata     (wdata),
  .rdata     (rdata),
  .xfer_clr  (xfer_clr),
  .irq       (irq),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .wday_o    (wday_o),
  .alarm_hit (alarm_hit),
  .min_step  (min_step)
);

// File: tb/test_rtc_alarm_adj.sv
module test_rtc_alarm_adj;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 2;
  localparam int N_ADJ      = 6;
  // round-command table: seconds reached before the command, expected minute gain
  localparam int ADJ_SEC [N_ADJ] = '{0, 29, 30, 59, 45, 10};
  localparam int ADJ_INC [N_ADJ] = '{0, 0, 1, 1, 1, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_rst = 1'b0, base_tick = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, xfer_clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [5:0] alm_min = 6'd5;
  logic [4:0] alm_hour = 5'd0;
  logic [2:0] alm_wday = 3'd0;
  logic [2:0] alm_en = 3'b001;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o;
  logic [2:0] wday_o;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_adj #(.TICKS_PER_SEC(TPS)) i_rtc_alarm_adj (
    .clk(clk), .rst_n(rst_n), .clk_rst(clk_rst), .base_tick(base_tick),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
    .xfer_clr(xfer_clr), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_wday(alm_wday), .alm_en(alm_en), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();  @(negedge clk); endtask
  task automatic base();  base_tick = 1'b1; @(negedge clk); base_tick = 1'b0; endtask
  task automatic rd();    rd_stb = 1'b1;    @(negedge clk); rd_stb = 1'b0;    endtask
  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1; wdata = d; @(negedge clk); wr_stb = 1'b0; wdata = 8'h00;
  endtask
  task automatic tick_secs(input int n);
    for (int i = 0; i < n * TPS; i++) base();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int m0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1 reset state
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset time", {sec_o, min_o, hour_o, wday_o}, 0);

    // R11 divider: one base tick is half a second
    base();
    chk("R11 half second", sec_o, 0);
    base();
    chk("R11 one second", sec_o, 1);

    // R8 rounding table, R10 busy bit
    for (int e = 0; e < N_ADJ; e++) begin
      wr(8'h13);
      chk("R10 busy during apply", rdata[7], 1);
      chk("R10 commands read 0", rdata[4:3], 0);
      idle();
      chk("R10 busy gone", rdata[7], 0);
      tick_secs(ADJ_SEC[e]);
      chk("R8 seconds reached", sec_o, ADJ_SEC[e]);
      m0 = int'(min_o);
      wr(8'h0B);
      idle();
      chk("R8 seconds zeroed", sec_o, 0);
      chk("R8 minute gain", min_o, m0 + ADJ_INC[e]);
    end
    chk("R6 minute flag after rounding", rdata[1], 1);

    // R2 / R3 read-then-write clear
    wr(8'h00);
    chk("R2 no clear without read", rdata[1], 1);
    rd();
    wr(8'h02);
    chk("R3 write 1 keeps minute flag", rdata[1], 1);
    chk("R3 write 1 does not set alarm flag", rdata[0], 0);
    rd();
    wr(8'h00);
    chk("R2 clear after read as 1", rdata[1], 0);
    chk("R1 reserved bits", rdata[6:5], 0);
    rd();
    tick_secs(30);
    wr(8'h0B);
    idle();
    chk("R6 minute flag set", rdata[1], 1);
    wr(8'h00);
    chk("R2 set after read of 0 survives", rdata[1], 1);

    // R5 alarm on minute field, R7 irq, R4 transfer clear
    tick_secs(30);
    wr(8'h0B);
    idle();
    chk("R5 minute now 5", min_o, 5);
    chk("R5 alarm flag set", rdata[0], 1);
    rd();
    wr(8'h01);
    chk("R2 minute flag cleared, alarm kept", rdata[1:0], 2'b01);
    chk("R7 irq masked by enable", irq, 0);
    wr(8'h07);
    chk("R7 irq with enable", irq, 1);
    xfer_clr = 1'b1; idle(); xfer_clr = 1'b0;
    chk("R4 transfer clear", rdata[0], 0);
    chk("R7 irq after clear", irq, 0);
    tick_secs(3);
    chk("R5 persisting match no reset", rdata[0], 0);

    // R12 adjustment meets second step in the same cycle
    tick_secs(28);
    base();
    wr(8'h0F);
    base();
    chk("R12 tick dropped", sec_o, 0);
    chk("R12 minute advanced", min_o, 6);
    chk("R6 flag on rounding", rdata[1], 1);

    // R9 second restart clears divider
    base();
    wr(8'h17);
    idle();
    base();
    chk("R9 divider restarted", sec_o, 0);
    base();
    chk("R9 next second", sec_o, 1);

    // R11 hour/weekday carry, R5 multi-field alarm
    rd();
    wr(8'h05);
    alm_min = 6'd0; alm_hour = 5'd0; alm_wday = 3'd1; alm_en = 3'b111;
    for (int m = 0; m < 23 * 60 + 59 - 6; m++) begin
      tick_secs(30);
      wr(8'h1F);
      idle();
    end
    chk("R11 before midnight", {hour_o, min_o, wday_o}, {5'd23, 6'd59, 3'd0});
    chk("R5 no early alarm", rdata[0], 0);
    tick_secs(30);
    wr(8'h1F);
    idle();
    chk("R11 midnight carry", {hour_o, min_o, wday_o}, {5'd0, 6'd0, 3'd1});
    chk("R5 all-field alarm", rdata[0], 1);
    chk("R7 irq", irq, 1);

    // R13 clock reset command
    clk_rst = 1'b1; idle(); clk_rst = 1'b0;
    chk("R13 rdata cleared", rdata, 8'h00);
    chk("R13 irq cleared", irq, 0);
    chk("R13 time cleared", {sec_o, min_o, hour_o, wday_o}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule